// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor and a source controller. It keeps one pending slot that holds a single interrupt for the processor. Device sources reach the slot through a delivery port that carries a source number and a priority. Inter-processor interrupts reach it through a programmable IPI priority register. A smaller priority number is more favoured, and the all-ones priority means masked. The processor steers the block with five register operations: accept, set current priority, set IPI priority, end-of-interrupt and poll. The block drives one level interrupt line to the processor.

A newer, more favoured delivery can push a pending device interrupt out of the slot. Lowering the current priority can also clear the slot. In both cases the displaced device source is bounced back to its controller with a reject strobe. End-of-interrupt strobes and resend requests go to the controller in the same way, so that it can present its sources again.

The delivery port uses valid/ready. A delivery is taken only in a cycle where `dlv_valid` and `dlv_ready` are both high. `dlv_ready` is low in every cycle that carries a processor operation, and the source must then hold its delivery until it is taken. Processor operations are always taken when `op_valid` is high. The response, reject, EOI and resend outputs are single-cycle strobes with no back-pressure.

Top module: `intr_presenter`

## Requirements
- R1: After reset the request word (current priority in bits 31:24, pending source number in bits 23:0) is zero, the pending priority and the IPI priority are 0xFF, and the interrupt line and all strobes are low.
- R2: At most one command is taken per clock, and a processor operation wins over a delivery. `dlv_ready` equals the inverse of `op_valid`, and a delivery offered next to an operation has no effect.
- R3: A delivery is rejected, with `rej_valid` carrying the delivered number and no change of state, when its priority is not strictly below the current priority, or when a source is pending at a priority less than or equal to the new one.
- R4: A delivery that is not rejected latches its number and priority, marks the slot device-owned and raises the interrupt line. If a device-owned source was pending, a reject strobe carries the old number in the same cycle.
- R5: Accept (op code 0) returns the request word as it was before the operation and lowers the line. The current priority becomes the pending priority, the source number becomes zero and the pending priority becomes 0xFF.
- R6: Poll (op code 4) returns the request word and the IPI priority and changes nothing.
- R7: Set current priority (op code 1, value in data bits 7:0) to a value below the old one, with a source pending and the value less than or equal to the pending priority, clears the slot, sets the pending priority to 0xFF and lowers the line. If the slot was device-owned, it also rejects the pending source.
- R8: Set current priority to a value not below the old one, with nothing pending, pulses `resend_req`. If the IPI priority is below the new current priority, the IPI (source number 2) is latched at the IPI priority.
- R9: Set IPI priority (op code 2, value in data bits 7:0) stores the value. If it is below the current priority and no source is pending at a priority less than or equal to it, any device-owned pending source is rejected, number 2 is latched at the IPI priority and the line rises.
- R10: A pending IPI is never rejected to the source controller, whether it is displaced by a delivery or cleared by a priority change.
- R11: End-of-interrupt (op code 3) sets the current priority from data bits 31:24 and strobes `eoi_valid` with data bits 23:0. If nothing is pending, it also pulses `resend_req` and runs the IPI check of R8.
- R12: Every strobe and response is visible in the cycle after the command was taken and lasts exactly one cycle. A cycle with no command produces no strobe.
- R13: `irq_out` is high exactly when the pending source number is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation present |
| op_code | input | 3 | 0 accept, 1 set current priority, 2 set IPI priority, 3 end-of-interrupt, 4 poll |
| op_data | input | 32 | Operation operand |
| dlv_valid | input | 1 | Delivery offered by the source controller |
| dlv_ready | output | 1 | Delivery taken this cycle when high together with valid |
| dlv_num | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| irq_out | output | 1 | Level interrupt to the processor |
| rsp_valid | output | 1 | Response strobe for accept and poll |
| rsp_word | output | 32 | Request word returned |
| rsp_ipi | output | 8 | IPI priority returned |
| rej_valid | output | 1 | Reject strobe to the source controller |
| rej_num | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_num | output | 24 | Source number being ended |
| resend_req | output | 1 | Resend request strobe |

## Verification
On every cycle the assertions check that the line follows the pending number, that an accept clears the slot and answers, that a priority-blocked delivery bounces with its own number, that a free slot latches a favoured delivery, that end-of-interrupt restores priority and forwards the number, and that no reject is ever raised for an IPI. Other behaviour depends on the history of operations, and only the bench's scenarios show it. This covers preemption chains in which a device displaces an IPI and an IPI displaces a device, the tie case where equal priority is refused, resend triggered by raising the priority or by an end-of-interrupt, a priority drop that leaves an empty slot untouched, and a delivery stalled under an operation.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_SET_CPPR = 3'd1,
    OP_SET_IPI  = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } pres_op_e;
endpackage

// File: rtl/ipres_front.sv
module ipres_front (
  input  logic op_valid,
  input  logic dlv_valid,
  output logic dlv_ready,
  output logic op_go,
  output logic dlv_go
);
  // processor operations take the cycle; deliveries wait
  assign op_go     = op_valid;
  assign dlv_ready = !op_valid;
  assign dlv_go    = dlv_valid && !op_valid;
endmodule

// File: rtl/ipres_engine.sv
module ipres_engine
  import ipres_pkg::*;
#(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2,
  localparam int REG_W  = NUM_W + PRIO_W
) (
  input  logic              op_go,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_data,
  input  logic              dlv_go,
  input  logic [NUM_W-1:0]  dlv_num,
  input  logic [PRIO_W-1:0] dlv_prio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [NUM_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pp,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic              owned,
  output logic [PRIO_W-1:0] n_cppr,
  output logic [NUM_W-1:0]  n_xisr,
  output logic [PRIO_W-1:0] n_pp,
  output logic [PRIO_W-1:0] n_mfrr,
  output logic              n_owned,
  output logic              rej_go,
  output logic [NUM_W-1:0]  rej_id,
  output logic              eoi_go,
  output logic [NUM_W-1:0]  eoi_id,
  output logic              rsnd_go,
  output logic              rsp_go,
  output logic [REG_W-1:0]  rsp_w,
  output logic [PRIO_W-1:0] rsp_i
);
  localparam logic [PRIO_W-1:0] MASKED  = {PRIO_W{1'b1}};
  localparam logic [NUM_W-1:0]  IPI_SRC = NUM_W'(IPI_NUM);

  logic              run_ipi;
  logic [PRIO_W-1:0] wr_prio;

  assign wr_prio = op_data[PRIO_W-1:0];

  always_comb begin
    n_cppr  = cppr;
    n_xisr  = xisr;
    n_pp    = pp;
    n_mfrr  = mfrr;
    n_owned = owned;
    rej_go  = 1'b0;
    rej_id  = xisr;
    eoi_go  = 1'b0;
    eoi_id  = op_data[NUM_W-1:0];
    rsnd_go = 1'b0;
    rsp_go  = 1'b0;
    rsp_w   = {cppr, xisr};
    rsp_i   = mfrr;
    run_ipi = 1'b0;
    if (op_go) begin
      case (pres_op_e'(op_code))
        OP_ACCEPT: begin
          rsp_go  = 1'b1;
          n_cppr  = pp;
          n_xisr  = '0;
          n_pp    = MASKED;
          n_owned = 1'b0;
        end
        OP_POLL: rsp_go = 1'b1;
        OP_SET_CPPR: begin
          n_cppr = wr_prio;
          if (wr_prio < cppr) begin
            if (xisr != '0 && wr_prio <= pp) begin
              rej_go  = owned;
              n_xisr  = '0;
              n_pp    = MASKED;
              n_owned = 1'b0;
            end
          end else if (xisr == '0) begin
            rsnd_go = 1'b1;
            run_ipi = mfrr < wr_prio;
          end
        end
        OP_SET_IPI: begin
          n_mfrr  = wr_prio;
          run_ipi = wr_prio < cppr;
        end
        OP_EOI: begin
          n_cppr = op_data[REG_W-1:NUM_W];
          eoi_go = 1'b1;
          if (xisr == '0) begin
            rsnd_go = 1'b1;
            run_ipi = mfrr < op_data[REG_W-1:NUM_W];
          end
        end
        default: ;
      endcase
    end else if (dlv_go) begin
      if (dlv_prio >= cppr || (xisr != '0 && pp <= dlv_prio)) begin
        rej_go = 1'b1;
        rej_id = dlv_num;
      end else begin
        rej_go  = xisr != '0 && owned;
        n_xisr  = dlv_num;
        n_pp    = dlv_prio;
        n_owned = 1'b1;
      end
    end
    // IPI competes for the slot after the operation's own update
    if (run_ipi && !(n_xisr != '0 && n_pp <= n_mfrr)) begin
      if (n_xisr != '0 && n_owned) begin
        rej_go = 1'b1;
        rej_id = n_xisr;
      end
      n_xisr  = IPI_SRC;
      n_pp    = n_mfrr;
      n_owned = 1'b0;
    end
  end

  // R10: a reject raised by a processor operation always belongs to a device-owned slot
  always_comb begin
    if (op_go && rej_go) begin
      a_r10_ipi_not_rejected: assert (owned && rej_id != IPI_SRC);
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2,
  localparam int REG_W  = NUM_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_data,
  input  logic              dlv_valid,
  output logic              dlv_ready,
  input  logic [NUM_W-1:0]  dlv_num,
  input  logic [PRIO_W-1:0] dlv_prio,
  output logic              irq_out,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_word,
  output logic [PRIO_W-1:0] rsp_ipi,
  output logic              rej_valid,
  output logic [NUM_W-1:0]  rej_num,
  output logic              eoi_valid,
  output logic [NUM_W-1:0]  eoi_num,
  output logic              resend_req
);
  localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

  logic              op_go, dlv_go;
  logic [PRIO_W-1:0] cppr_q, pp_q, mfrr_q, n_cppr, n_pp, n_mfrr;
  logic [NUM_W-1:0]  xisr_q, n_xisr, rej_id, eoi_id;
  logic              owned_q, n_owned, rej_go, eoi_go, rsnd_go, rsp_go;
  logic [REG_W-1:0]  rsp_w;
  logic [PRIO_W-1:0] rsp_i;

  ipres_front u_front (
    .op_valid (op_valid),
    .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready),
    .op_go    (op_go),
    .dlv_go   (dlv_go)
  );

  ipres_engine #(.NUM_W(NUM_W), .PRIO_W(PRIO_W), .IPI_NUM(IPI_NUM)) u_engine (
    .op_go   (op_go),
    .op_code (op_code),
    .op_data (op_data),
    .dlv_go  (dlv_go),
    .dlv_num (dlv_num),
    .dlv_prio(dlv_prio),
    .cppr    (cppr_q),
    .xisr    (xisr_q),
    .pp      (pp_q),
    .mfrr    (mfrr_q),
    .owned   (owned_q),
    .n_cppr  (n_cppr),
    .n_xisr  (n_xisr),
    .n_pp    (n_pp),
    .n_mfrr  (n_mfrr),
    .n_owned (n_owned),
    .rej_go  (rej_go),
    .rej_id  (rej_id),
    .eoi_go  (eoi_go),
    .eoi_id  (eoi_id),
    .rsnd_go (rsnd_go),
    .rsp_go  (rsp_go),
    .rsp_w   (rsp_w),
    .rsp_i   (rsp_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q     <= '0;
      xisr_q     <= '0;
      pp_q       <= MASKED;
      mfrr_q     <= MASKED;
      owned_q    <= 1'b0;
      irq_out    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
      rsp_ipi    <= '0;
      rej_valid  <= 1'b0;
      rej_num    <= '0;
      eoi_valid  <= 1'b0;
      eoi_num    <= '0;
      resend_req <= 1'b0;
    end else begin
      cppr_q     <= n_cppr;
      xisr_q     <= n_xisr;
      pp_q       <= n_pp;
      mfrr_q     <= n_mfrr;
      owned_q    <= n_owned;
      irq_out    <= n_xisr != '0;
      rsp_valid  <= rsp_go;
      rsp_word   <= rsp_w;
      rsp_ipi    <= rsp_i;
      rej_valid  <= rej_go;
      rej_num    <= rej_id;
      eoi_valid  <= eoi_go;
      eoi_num    <= eoi_id;
      resend_req <= rsnd_go;
    end
  end

  a_r13_line_follows_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  a_r3_blocked_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_prio >= cppr_q)
      |=> (rej_valid && rej_num == $past(dlv_num)));

  a_r4_free_slot_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_prio < cppr_q && xisr_q == '0)
      |=> (irq_out && xisr_q == $past(dlv_num) && !rej_valid));

  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0)
      |=> (!irq_out && rsp_valid && xisr_q == '0 && pp_q == MASKED));

  a_r11_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3)
      |=> (eoi_valid && eoi_num == $past(op_data[NUM_W-1:0])
           && cppr_q == $past(op_data[REG_W-1:NUM_W])));

  a_r12_rsp_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(op_valid && (op_code == 3'd0 || op_code == 3'd4)));
endmodule

// File: tb/test_intr_presenter.sv
module test_intr_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        dlv_valid = 1'b0;
  logic        dlv_ready;
  logic [23:0] dlv_num = '0;
  logic [7:0]  dlv_prio = '0;
  logic        irq_out, rsp_valid, rej_valid, eoi_valid, resend_req;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_ipi;
  logic [23:0] rej_num, eoi_num;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  intr_presenter i_intr_presenter (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
    .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req)
  );

  typedef struct {
    string       tag;
    logic        rej;
    logic [23:0] rejn;
    logic        eoi;
    logic [23:0] eoin;
    logic        rs;
    logic        rsp;
    logic [31:0] rw;
    logic [7:0]  ri;
    logic        irq;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;

  // reference state built from the requirements
  logic [7:0]  m_cppr, m_pp, m_mfrr;
  logic [23:0] m_xisr;
  logic        m_own;

  task automatic ipi_check();
    if (m_xisr != 0 && m_pp <= m_mfrr) return;
    if (m_xisr != 0 && m_own) begin e.rej = 1'b1; e.rejn = m_xisr; end
    m_xisr = 24'd2;
    m_pp   = m_mfrr;
    m_own  = 1'b0;
  endtask

  task automatic model(input bit ov, input logic [2:0] oc, input logic [31:0] od,
                       input bit dv, input logic [23:0] dn, input logic [7:0] dp);
    logic [7:0] v;
    v = od[7:0];
    if (ov) begin
      case (oc)
        3'd0: begin
          e.rsp = 1'b1; e.rw = {m_cppr, m_xisr}; e.ri = m_mfrr;
          m_cppr = m_pp; m_xisr = 0; m_pp = 8'hFF; m_own = 1'b0;
        end
        3'd4: begin e.rsp = 1'b1; e.rw = {m_cppr, m_xisr}; e.ri = m_mfrr; end
        3'd1: begin
          if (v < m_cppr) begin
            m_cppr = v;
            if (m_xisr != 0 && v <= m_pp) begin
              if (m_own) begin e.rej = 1'b1; e.rejn = m_xisr; end
              m_xisr = 0; m_pp = 8'hFF; m_own = 1'b0;
            end
          end else begin
            m_cppr = v;
            if (m_xisr == 0) begin
              e.rs = 1'b1;
              if (m_mfrr < m_cppr) ipi_check();
            end
          end
        end
        3'd2: begin
          m_mfrr = v;
          if (m_mfrr < m_cppr) ipi_check();
        end
        3'd3: begin
          m_cppr = od[31:24]; e.eoi = 1'b1; e.eoin = od[23:0];
          if (m_xisr == 0) begin
            e.rs = 1'b1;
            if (m_mfrr < m_cppr) ipi_check();
          end
        end
        default: ;
      endcase
    end else if (dv) begin
      if (dp >= m_cppr || (m_xisr != 0 && m_pp <= dp)) begin
        e.rej = 1'b1; e.rejn = dn;
      end else begin
        if (m_xisr != 0 && m_own) begin e.rej = 1'b1; e.rejn = m_xisr; end
        m_xisr = dn; m_pp = dp; m_own = 1'b1;
      end
    end
    e.irq = (m_xisr != 0);
  endtask

  task automatic drive(input bit ov, input logic [2:0] oc, input logic [31:0] od,
                       input bit dv, input logic [23:0] dn, input logic [7:0] dp,
                       input string tag);
    @(negedge clk);
    op_valid = ov; op_code = oc; op_data = od;
    dlv_valid = dv; dlv_num = dn; dlv_prio = dp;
    e = '{tag: tag, rej: 0, rejn: 0, eoi: 0, eoin: 0, rs: 0, rsp: 0, rw: 0, ri: 0, irq: 0};
    model(ov, oc, od, dv, dn, dp);
    exp_q.push_back(e);
    #1;
    checks++;
    if (dlv_ready !== !ov) begin
      fails++;
      $display("FAIL R2 ready under op: actual %0b expected %0b", dlv_ready, !ov);
    end
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 3'd0, 32'd0, 1'b0, 24'd0, 8'd0, tag);
  endtask

  // monitor: one expected record per cycle in which a command was driven
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        exp_t x;
        logic bad;
        x = exp_q.pop_front();
        bad = (rej_valid !== x.rej) || (x.rej && rej_num !== x.rejn)
           || (eoi_valid !== x.eoi) || (x.eoi && eoi_num !== x.eoin)
           || (resend_req !== x.rs) || (rsp_valid !== x.rsp)
           || (x.rsp && (rsp_word !== x.rw || rsp_ipi !== x.ri))
           || (irq_out !== x.irq);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: actual rej=%0b/%h eoi=%0b/%h rs=%0b rsp=%0b/%h/%h irq=%0b expected rej=%0b/%h eoi=%0b/%h rs=%0b rsp=%0b/%h/%h irq=%0b",
                   x.tag, rej_valid, rej_num, eoi_valid, eoi_num, resend_req, rsp_valid, rsp_word,
                   rsp_ipi, irq_out, x.rej, x.rejn, x.eoi, x.eoin, x.rs, x.rsp, x.rw, x.ri, x.irq);
        end
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_cppr = 8'h00; m_xisr = 0; m_pp = 8'hFF; m_mfrr = 8'hFF; m_own = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (irq_out !== 1'b0 || rej_valid !== 1'b0 || eoi_valid !== 1'b0 || resend_req !== 1'b0 || rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual irq=%0b rej=%0b eoi=%0b rs=%0b rsp=%0b expected all 0",
               irq_out, rej_valid, eoi_valid, resend_req, rsp_valid);
    end
    drive(1, 3'd4, 32'h0, 0, 0, 0, "R1 R6 poll after reset");
    drive(0, 0, 0, 1, 24'h10, 8'h05, "R3 delivery blocked by priority 0");
    drive(1, 3'd1, 32'hFF, 0, 0, 0, "R8 raise priority empty slot resend");
    drive(0, 0, 0, 1, 24'h10, 8'h05, "R4 delivery latched");
    drive(0, 0, 0, 1, 24'h20, 8'h07, "R3 less favoured than pending");
    drive(0, 0, 0, 1, 24'h20, 8'h05, "R3 equal to pending priority");
    drive(0, 0, 0, 1, 24'h30, 8'h03, "R4 preempt device and reject old");
    drive(1, 3'd4, 32'h0, 0, 0, 0, "R6 poll pending word");
    drive(1, 3'd2, 32'h08, 1, 24'h40, 8'h01, "R2 R9 op wins, IPI skipped");
    idle("R12 idle no strobes");
    drive(1, 3'd2, 32'h01, 0, 0, 0, "R9 IPI preempts device");
    drive(0, 0, 0, 1, 24'h50, 8'h00, "R10 device preempts IPI silently");
    drive(1, 3'd0, 32'h0, 0, 0, 0, "R5 accept");
    drive(1, 3'd3, 32'hFF000050, 0, 0, 0, "R11 eoi resend and IPI");
    drive(1, 3'd1, 32'h01, 0, 0, 0, "R7 R10 lower priority clears IPI");
    drive(1, 3'd1, 32'h06, 0, 0, 0, "R8 raise priority latches IPI");
    drive(1, 3'd2, 32'hFF, 0, 0, 0, "R9 mask IPI no effect");
    drive(1, 3'd0, 32'h0, 0, 0, 0, "R5 accept IPI");
    drive(1, 3'd3, 32'h06000002, 0, 0, 0, "R11 eoi of IPI");
    drive(0, 0, 0, 1, 24'h60, 8'h04, "R4 latch before lowering");
    drive(1, 3'd1, 32'h04, 0, 0, 0, "R7 lower to pending priority rejects");
    drive(1, 3'd1, 32'h02, 0, 0, 0, "R7 lower with empty slot no effect");
    drive(1, 3'd4, 32'h0, 0, 0, 0, "R6 R13 final poll");
    idle("R12 idle");
    idle("R12 idle");
    @(negedge clk);
    op_valid = 1'b0; dlv_valid = 1'b0;
    repeat (3) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule